// File: doc/BRIEF.md
# Collision Backoff Countdown Generator

After a transmit collision, this block picks a randomized retransmission delay and counts it down. It keeps a backoff load word. On every collision it accepts, the load grows as `(old << 1) + 1`. The block takes a random byte from a window of a free-running timer. It masks that byte with the old load, and the result is the starting count. A periodic tick decrements the count, and when the count is already zero a tick fires a one-cycle transmit-start pulse.

If the load already has its top bit set, the collision is refused with an overflow abort code. While the countdown runs, the receiver can stay enabled, so a packet that arrives during the wait is handed to the receive path. Any post or command event during the wait ends the countdown with an abort code. All pins are plain control and status pins with no stream handshake. Pulses last one cycle and are not held for a consumer.

Top module: `backoff_timer`

## Requirements
- R1: After reset, `busy_o`, `tx_start_o`, `rx_en_o` and `abort_o` are 0 and `load_o` is 0.
- R2: A collision accepted in idle replaces the load with `(old << 1) + 1`, visible on `load_o` one cycle later.
- R3: A collision while bit 15 of the load is 1 is refused: `abort_o` pulses with `abort_code_o` = 16'h03FF (octal 1777), the load is unchanged and `busy_o` stays 0.
- R4: The random byte is `timer_i[9:2]`, sampled in the collision cycle.
- R5: The starting count is the random byte ANDed with bits [7:0] of the load from before the update.
- R6: While busy, each tick with count N > 0 makes it N-1. A tick with count 0 ends the wait with a one-cycle `tx_start_o` one cycle after that tick, so a starting count N gives the pulse after tick N+1.
- R7: Ticks in idle have no effect (no `tx_start_o`). Collisions while busy have no effect on the load or the count.
- R8: `rx_en_o` is 1 during a countdown exactly when `rxbuf_set_i` was 1 at the accepted collision. `rx_handoff_o` = `pkt_arrive_i` AND `rx_en_o`.
- R9: `evt_i` while busy ends the wait with an `abort_o` pulse, `abort_code_o` = 16'h05FF (octal 2777), no `tx_start_o`, and `rx_en_o` low. It wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coll_i | input | 1 | Collision pulse, starts a backoff |
| evt_i | input | 1 | Post or command event, aborts the wait |
| tick_i | input | 1 | Periodic single-cycle tick |
| timer_i | input | 16 | Free-running timer value |
| rxbuf_set_i | input | 1 | An input buffer is set up |
| pkt_arrive_i | input | 1 | Incoming packet first word present |
| busy_o | output | 1 | Countdown in progress |
| tx_start_o | output | 1 | One-cycle transmit start |
| rx_en_o | output | 1 | Receiver enabled during the wait |
| rx_handoff_o | output | 1 | Packet passed to receive path |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_code_o | output | 16 | Abort status, valid with `abort_o` |
| load_o | output | 16 | Current backoff load |

## Verification
Every registered result appears one cycle after the edge that samples its cause. This covers `load_o`, `busy_o`, `rx_en_o`, `abort_o` with its code after a collision or event, and `tx_start_o` after the terminal tick. The bench drives inputs at the falling edge and samples outputs at the next falling edge, so each check lands in the cycle after the stimulus edge. The bench checks `rx_handoff_o` a moment after driving `pkt_arrive_i`, in the same cycle, because that output is combinational. Countdown lengths are checked tick by tick, and the bench expects the pulse exactly after tick N+1.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  localparam logic [15:0] CODE_LOAD_OVF = 16'h03FF;
  localparam logic [15:0] CODE_ABORT    = 16'h05FF;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} bo_state_t;
endpackage

// File: rtl/backoff_load.sv
module backoff_load #(
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  output logic [LOAD_W-1:0] load_o,
  output logic              ovf_o
);
  logic [LOAD_W-1:0] load_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     load_q <= '0;
    else if (upd_i) load_q <= {load_q[LOAD_W-2:0], 1'b1};
  end

  assign load_o = load_q;
  assign ovf_o  = load_q[LOAD_W-1];

  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> load_q == (($past(load_q) << 1) | LOAD_W'(1)));   // R2
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(load_q));   // R3
endmodule

// File: rtl/backoff_rand.sv
module backoff_rand #(
  parameter int TIMER_W  = 16,
  parameter int RAND_W   = 8,
  parameter int RAND_LSB = 2,
  parameter int LOAD_W   = 16
) (
  input  logic [TIMER_W-1:0] timer_i,
  input  logic [LOAD_W-1:0]  load_i,
  output logic [RAND_W-1:0]  seed_o
);
  logic [RAND_W-1:0] rnd;
  assign rnd    = timer_i[RAND_LSB +: RAND_W];
  assign seed_o = rnd & load_i[RAND_W-1:0];
endmodule

// File: rtl/backoff_count.sv
module backoff_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i && zero_o) |=> zero_o);   // R6
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
  import backoff_pkg::*;
#(
  parameter int LOAD_W   = 16,
  parameter int TIMER_W  = 16,
  parameter int RAND_W   = 8,
  parameter int RAND_LSB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coll_i,
  input  logic               evt_i,
  input  logic               tick_i,
  input  logic [TIMER_W-1:0] timer_i,
  input  logic               rxbuf_set_i,
  input  logic               pkt_arrive_i,
  output logic               busy_o,
  output logic               tx_start_o,
  output logic               rx_en_o,
  output logic               rx_handoff_o,
  output logic               abort_o,
  output logic [15:0]        abort_code_o,
  output logic [LOAD_W-1:0]  load_o
);
  bo_state_t         state_q;
  logic [LOAD_W-1:0] load_w;
  logic              ovf_w, zero_w;
  logic [RAND_W-1:0] seed_w;
  logic              start_w, refuse_w, kill_w, fire_w, dec_w;
  logic              tx_q, rxen_q, abt_q;
  logic [15:0]       code_q;

  assign start_w  = (state_q == ST_IDLE) && coll_i && !ovf_w;
  assign refuse_w = (state_q == ST_IDLE) && coll_i && ovf_w;
  assign kill_w   = (state_q == ST_WAIT) && evt_i;
  assign dec_w    = (state_q == ST_WAIT) && !evt_i && tick_i;
  assign fire_w   = dec_w && zero_w;

  backoff_load #(.LOAD_W(LOAD_W)) u_load (
    .clk(clk), .rst_n(rst_n), .upd_i(start_w), .load_o(load_w), .ovf_o(ovf_w));

  backoff_rand #(.TIMER_W(TIMER_W), .RAND_W(RAND_W), .RAND_LSB(RAND_LSB),
                 .LOAD_W(LOAD_W)) u_rand (
    .timer_i(timer_i), .load_i(load_w), .seed_o(seed_w));

  backoff_count #(.CNT_W(RAND_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_i(start_w), .ld_val_i(seed_w),
    .dec_i(dec_w), .zero_o(zero_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= 1'b0;
      rxen_q  <= 1'b0;
      abt_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      tx_q  <= fire_w;
      abt_q <= refuse_w || kill_w;
      if (refuse_w)    code_q <= CODE_LOAD_OVF;
      else if (kill_w) code_q <= CODE_ABORT;
      if (start_w) begin
        state_q <= ST_WAIT;
        rxen_q  <= rxbuf_set_i;
      end else if (kill_w || fire_w) begin
        state_q <= ST_IDLE;
        rxen_q  <= 1'b0;
      end
    end
  end

  assign busy_o       = (state_q == ST_WAIT);
  assign tx_start_o   = tx_q;
  assign rx_en_o      = rxen_q;
  assign rx_handoff_o = rxen_q && pkt_arrive_i;
  assign abort_o      = abt_q;
  assign abort_code_o = code_q;
  assign load_o       = load_w;

  AST_TX_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> !busy_o && $past(busy_o));   // R6
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && tick_i) |=> !tx_start_o);   // R7
  AST_RXEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rx_en_o);   // R8
  AST_EVT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && evt_i) |=> abort_o && !tx_start_o && abort_code_o == CODE_ABORT);   // R9
  AST_OVF_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && coll_i && load_o[LOAD_W-1]) |=> abort_o && !busy_o
      && abort_code_o == CODE_LOAD_OVF);   // R3
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_start_o, abort_o}));   // R9
endmodule

// File: tb/backoff_timer_tb.sv
module backoff_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coll = 1'b0, evt = 1'b0, tick = 1'b0, rxbuf = 1'b0, pkt = 1'b0;
  logic [15:0] timer = '0;
  logic busy, txs, rxen, hand, abt;
  logic [15:0] code, load;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  backoff_timer u_dut (
    .clk(clk), .rst_n(rst_n), .coll_i(coll), .evt_i(evt), .tick_i(tick),
    .timer_i(timer), .rxbuf_set_i(rxbuf), .pkt_arrive_i(pkt),
    .busy_o(busy), .tx_start_o(txs), .rx_en_o(rxen), .rx_handoff_o(hand),
    .abort_o(abt), .abort_code_o(code), .load_o(load));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; coll = 0; evt = 0; tick = 0; pkt = 0; rxbuf = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_coll(logic [15:0] t);
    timer = t; coll = 1'b1;
    @(negedge clk); coll = 1'b0;
  endtask

  task automatic pulse_evt();
    evt = 1'b1; @(negedge clk); evt = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  // count N must produce tx_start after tick N+1 and not before
  task automatic expect_ticks(string req, int n);
    for (int i = 0; i <= n; i++) begin
      pulse_tick();
      chk(req, {15'd0, txs}, {15'd0, (i == n)});
    end
    chk(req, {15'd0, busy}, 16'd0);
  endtask

  // reach load 2^k-1 using aborted waits
  task automatic grow_load(int k);
    for (int i = 0; i < k; i++) begin
      pulse_coll(16'h0000);
      pulse_evt();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 tx", {15'd0, txs}, 16'd0);
    chk("R1 rxen", {15'd0, rxen}, 16'd0);
    chk("R1 abort", {15'd0, abt}, 16'd0);
    chk("R1 load", load, 16'd0);
  endtask

  task automatic t_zero_count();
    do_reset();
    pulse_coll(16'hFFFF);
    chk("R2 load", load, 16'h0001);
    chk("R6 busy", {15'd0, busy}, 16'd1);
    expect_ticks("R6 zero count", 0);
    pulse_coll(16'h0000);
    chk("R2 load 3", load, 16'h0003);
    expect_ticks("R6 zero seed", 0);
  endtask

  task automatic t_masking();
    do_reset();
    grow_load(3);
    chk("R2 load 7", load, 16'h0007);
    pulse_coll(16'h03FC);  // byte FF & 07 -> 7
    chk("R2 load 15", load, 16'h000F);
    expect_ticks("R5 count 7", 7);
    pulse_coll(16'h0014);  // byte 05 & 0F -> 5
    expect_ticks("R4 count 5", 5);
    pulse_coll(16'hFC03);  // window bits 0 -> 0
    expect_ticks("R4 window", 0);
  endtask

  task automatic t_ignore();
    do_reset();
    pulse_tick();
    chk("R7 idle tick", {15'd0, txs}, 16'd0);
    chk("R7 idle busy", {15'd0, busy}, 16'd0);
    grow_load(2);
    pulse_coll(16'h000C);  // byte 03 & 03 -> 3, load 7
    pulse_coll(16'hFFFF);
    chk("R7 coll in wait load", load, 16'h0007);
    expect_ticks("R7 coll in wait count", 3);
  endtask

  task automatic t_rx();
    do_reset();
    rxbuf = 1'b1;
    pulse_coll(16'h0000);
    rxbuf = 1'b0;
    chk("R8 rxen", {15'd0, rxen}, 16'd1);
    pkt = 1'b1; #1;
    chk("R8 handoff", {15'd0, hand}, 16'd1);
    @(negedge clk); pkt = 1'b0; #1;
    chk("R8 handoff low", {15'd0, hand}, 16'd0);
    @(negedge clk);
    evt = 1'b1; tick = 1'b1;
    @(negedge clk); evt = 1'b0; tick = 1'b0;
    chk("R9 abort", {15'd0, abt}, 16'd1);
    chk("R9 code", code, 16'h05FF);
    chk("R9 no tx", {15'd0, txs}, 16'd0);
    chk("R9 rxen low", {15'd0, rxen}, 16'd0);
    pulse_coll(16'h0000);
    chk("R8 no buf", {15'd0, rxen}, 16'd0);
    pkt = 1'b1; #1;
    chk("R8 no handoff", {15'd0, hand}, 16'd0);
    @(negedge clk); pkt = 1'b0;
  endtask

  task automatic t_overflow();
    do_reset();
    grow_load(16);
    chk("R2 load full", load, 16'hFFFF);
    pulse_coll(16'h0000);
    chk("R3 abort", {15'd0, abt}, 16'd1);
    chk("R3 code", code, 16'h03FF);
    chk("R3 busy", {15'd0, busy}, 16'd0);
    chk("R3 load kept", load, 16'hFFFF);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_zero_count();
        t_masking();
        t_ignore();
        t_rx();
        t_overflow();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule